// File: doc/BRIEF.md
# Per-Pin Trigger-Mode Interrupt Detector

This block watches a vector of already-synchronized general-purpose input pins and raises one interrupt line whenever a pin shows its programmed trigger condition. Each pin selects one of five trigger conditions with its own 3-bit code: rising edge, falling edge, either edge, high level or low level. A detected condition sets a sticky status bit for that pin. Software clears that bit by pulsing the pin's bit in a write-one-to-clear acknowledge vector.

The mode codes arrive in two 32-bit words, one 4-bit nibble per pin. The lower word serves the first eight pins and the upper word serves the rest. Status is combined with a per-pin enable vector and a per-pin mask vector. The result is a displayed vector and a single interrupt output. The parameter `NPINS` (8 or 12, at most 16) sets how many lanes of the 16-bit port vectors are live.

Top module: `gpio_trig_detect`

## Requirements
- R1: Mode code 1 (rising edge) sets a pin's status in the cycle after its input is sampled high when the previous registered sample was low.
- R2: Mode code 0 (falling edge) sets status after a high-to-low change of the pin between consecutive samples.
- R3: Mode code 4 (either edge) sets status after any change of the pin between consecutive samples.
- R4: Mode code 3 (high level) and mode code 2 (low level) set status on every cycle the level holds, so an acknowledge cannot clear the bit while the level persists.
- R5: A 1 in acknowledge bit k clears status bit k on the next clock edge. A 0 leaves it unchanged.
- R6: When a new edge and an acknowledge of the same pin fall in the same cycle, the status bit stays set.
- R7: A pin whose enable bit is 0 never sets its status bit.
- R8: Mode codes 5, 6 and 7 never set status.
- R9: Pin k below 8 takes its code from bits [4k+2:4k] of the lower mode word. Pin k of 8 or above takes it from bits [4(k-8)+2:4(k-8)] of the upper word. Bit 4k+3 of each nibble is ignored.
- R10: Input bits at or above `NPINS` are ignored, and status and display bits at or above `NPINS` read as zero.
- R11: The display vector equals status AND enable AND NOT mask. The interrupt output is high exactly when that vector is nonzero. Masking does not clear status.
- R12: During reset and afterwards, status is zero. The first clock after reset records the pins without reporting any edge, so a pin that is already high causes no edge interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | Synchronized pin levels |
| mode_lo_i | input | 32 | Mode nibbles for pins 0 to 7 |
| mode_hi_i | input | 32 | Mode nibbles for pins 8 and above |
| en_i | input | 16 | Per-pin detection enable |
| mask_i | input | 16 | Per-pin interrupt mask (1 = masked) |
| ack_i | input | 16 | Write-one-to-clear acknowledge pulses |
| status_o | output | 16 | Sticky raw status |
| disp_o | output | 16 | Status that is enabled and not masked |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong previous-sample register or a wrong arming flag shows up one clock later at `status_o`. The visible symptoms are a bit that appears with no real transition, or a missed edge. A wrong nibble decode sets the wrong lane's status, or no lane at all. A stuck status bit surfaces at `status_o`, `disp_o` and `irq_o` in the cycle after the acknowledge that should have cleared it. The bench compares all three outputs against a behavioural model on every clock, so any such divergence is reported in the cycle it first appears.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;
  localparam int unsigned LANE_W   = 16;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned PER_WORD = WORD_W / NIB_W;

  typedef enum logic [MODE_W-1:0] {
    TM_FALL = 3'd0,
    TM_RISE = 3'd1,
    TM_LOW  = 3'd2,
    TM_HIGH = 3'd3,
    TM_BOTH = 3'd4
  } trig_mode_e;
endpackage

// File: rtl/gpio_mode_sel.sv
module gpio_mode_sel
  import gpio_trig_pkg::*;
#(
  parameter int unsigned NPINS = 12
) (
  input  logic [WORD_W-1:0]       mode_lo_i,
  input  logic [WORD_W-1:0]       mode_hi_i,
  output logic [NPINS*MODE_W-1:0] mode_o
);
  logic unused_mode;
  assign unused_mode = ^{mode_lo_i, mode_hi_i};

  for (genvar k = 0; k < NPINS; k++) begin : g_lane
    if (k < PER_WORD) begin : g_lo
      assign mode_o[k*MODE_W +: MODE_W] = mode_lo_i[k*NIB_W +: MODE_W];
    end else begin : g_hi
      assign mode_o[k*MODE_W +: MODE_W] = mode_hi_i[(k-PER_WORD)*NIB_W +: MODE_W];
    end
  end
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
  import gpio_trig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              prev_i,
  input  logic              armed_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              en_i,
  input  logic              ack_i,
  output logic              st_o
);
  logic hit, set, st_q;

  always_comb begin
    unique case (mode_i)
      TM_FALL: hit = armed_i & prev_i & ~pin_i;
      TM_RISE: hit = armed_i & ~prev_i & pin_i;
      TM_BOTH: hit = armed_i & (prev_i ^ pin_i);
      TM_LOW:  hit = ~pin_i;
      TM_HIGH: hit = pin_i;
      default: hit = 1'b0;
    endcase
  end

  assign set = en_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= 1'b0;
    else         st_q <= (st_q & ~ack_i) | set;
  end

  assign st_o = st_q;

  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set) |=> !st_o);
  a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ack_i && !st_o) |=> !st_o);
  a_r8_bad_code_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i > 3'd4 && !st_o) |=> !st_o);
  a_r4_level_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ((mode_i == TM_HIGH && pin_i) || (mode_i == TM_LOW && !pin_i))) |=> st_o);
  a_r6_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && armed_i && mode_i == TM_RISE && pin_i && !prev_i) |=> st_o);
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_trig_pkg::*;
#(
  parameter int unsigned NPINS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANE_W-1:0] pin_i,
  input  logic [WORD_W-1:0] mode_lo_i,
  input  logic [WORD_W-1:0] mode_hi_i,
  input  logic [LANE_W-1:0] en_i,
  input  logic [LANE_W-1:0] mask_i,
  input  logic [LANE_W-1:0] ack_i,
  output logic [LANE_W-1:0] status_o,
  output logic [LANE_W-1:0] disp_o,
  output logic              irq_o
);
  localparam int unsigned MW = NPINS * MODE_W;

  logic [MW-1:0]    mode;
  logic [NPINS-1:0] prev_q, st;
  logic             armed_q;
  logic             unused_in;

  assign unused_in = ^{pin_i, en_i, mask_i, ack_i};

  gpio_mode_sel #(.NPINS(NPINS)) u_mode_sel (
    .mode_lo_i (mode_lo_i),
    .mode_hi_i (mode_hi_i),
    .mode_o    (mode)
  );

  // First clock after reset only captures the pins.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= pin_i[NPINS-1:0];
      armed_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < NPINS; k++) begin : g_cell
    gpio_trig_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pin_i[k]),
      .prev_i  (prev_q[k]),
      .armed_i (armed_q),
      .mode_i  (mode[k*MODE_W +: MODE_W]),
      .en_i    (en_i[k]),
      .ack_i   (ack_i[k]),
      .st_o    (st[k])
    );
  end

  assign status_o = LANE_W'(st);
  assign disp_o   = LANE_W'(st & en_i[NPINS-1:0] & ~mask_i[NPINS-1:0]);
  assign irq_o    = |disp_o;

  a_r11_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|status_o));
  a_r12_first_clock_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !(|st) && (|pin_i[NPINS-1:0]) && !(|(mode_lo_i & 32'h2222_2222))
     && !(|(mode_hi_i & 32'h2222_2222))) |=> (status_o == '0));
endmodule

// File: tb/gpio_trig_detect_bench.sv
module gpio_trig_detect_bench;
  localparam int NP = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] pin = '0, en = '0, mask = '0, ack = '0;
  logic [31:0] mlo = '0, mhi = '0;
  logic [15:0] status, disp;
  logic        irq;

  int          errors = 0, checks = 0;
  bit          done = 0;
  string       cur_req = "R12";

  logic [15:0] m_st = '0, m_prev = '0;
  bit          m_armed = 0;

  always #5 clk = ~clk;

  gpio_trig_detect #(.NPINS(NP)) u_gpio_trig_detect (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .mode_lo_i(mlo), .mode_hi_i(mhi),
    .en_i(en), .mask_i(mask), .ack_i(ack),
    .status_o(status), .disp_o(disp), .irq_o(irq)
  );

  function automatic logic [31:0] all_code(input logic [3:0] c);
    return {8{c}};
  endfunction

  task automatic model_update();
    logic [15:0] nxt;
    nxt = '0;
    if (!rst_ni) begin
      m_st = '0; m_prev = '0; m_armed = 0;
      return;
    end
    for (int k = 0; k < NP; k++) begin
      logic [2:0] c;
      bit h;
      c = (k < 8) ? mlo[4*k +: 3] : mhi[4*(k-8) +: 3];
      case (c)
        3'd0: h = m_armed && m_prev[k] && !pin[k];
        3'd1: h = m_armed && !m_prev[k] && pin[k];
        3'd2: h = !pin[k];
        3'd3: h = pin[k];
        3'd4: h = m_armed && (m_prev[k] != pin[k]);
        default: h = 0;
      endcase
      nxt[k] = (m_st[k] && !ack[k]) || (en[k] && h);
    end
    m_st = nxt;
    m_prev = pin;
    m_armed = 1;
  endtask

  task automatic compare();
    logic [15:0] edisp;
    edisp = m_st & en & ~mask;
    checks++;
    if (status !== m_st) begin
      errors++;
      $display("FAIL %s status actual=%h expected=%h", cur_req, status, m_st);
    end
    checks++;
    if (disp !== edisp) begin
      errors++;
      $display("FAIL %s disp actual=%h expected=%h", cur_req, disp, edisp);
    end
    checks++;
    if (irq !== (|edisp)) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, |edisp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic pulse_ack(input logic [15:0] v);
    ack = v; step(1); ack = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R12: reset state, then no edge from pins already high
    cur_req = "R12";
    pin = 16'h0FFF; en = 16'hFFFF; mlo = all_code(4'h1); mhi = all_code(4'h1);
    @(negedge clk);
    step(3);
    rst_ni = 1'b1;
    step(3);
    // R1 rising
    cur_req = "R1";
    pin = '0; step(2);
    pin = 16'h0005; step(2);
    pulse_ack(16'h0FFF); step(1);
    // R2 falling
    cur_req = "R2";
    mlo = all_code(4'h0); mhi = all_code(4'h0);
    pin = 16'h0005; step(1); pin = '0; step(2);
    pulse_ack(16'h0FFF);
    // R3 either edge
    cur_req = "R3";
    mlo = all_code(4'h4); mhi = all_code(4'h4);
    pin = 16'h0002; step(1); pulse_ack(16'h0FFF); step(1);
    pin = '0; step(2); pulse_ack(16'h0FFF);
    // R4 levels hold against acknowledge
    cur_req = "R4";
    mlo = 32'h0002_3000; mhi = '0;
    pin = 16'h0008; step(2);
    pulse_ack(16'h0FFF); step(1);
    pin = 16'h0010; step(1); pulse_ack(16'h0018); step(1);
    pin = '0; mlo = '0; step(1); pulse_ack(16'h0FFF);
    // R5 acknowledge of 0 does nothing, of 1 clears one bit
    cur_req = "R5";
    mlo = all_code(4'h1); mhi = all_code(4'h1);
    pin = 16'h0003; step(1); pin = '0;
    pulse_ack(16'h0000); step(1);
    pulse_ack(16'h0001); step(1);
    pulse_ack(16'h0002);
    // R6 edge beats acknowledge
    cur_req = "R6";
    pin = 16'h0001; step(1); pin = '0; step(1);
    pin = 16'h0001; ack = 16'h0001; step(1); ack = '0; step(1);
    pin = '0; pulse_ack(16'h0FFF);
    // R7 enable clear
    cur_req = "R7";
    en = 16'h0FFE; mlo = all_code(4'h4);
    pin = 16'h0001; step(1); pin = '0; step(1);
    mlo = all_code(4'h3); pin = 16'h0001; step(2); pin = '0;
    en = 16'hFFFF; mlo = all_code(4'h1); step(1);
    // R8 reserved codes
    cur_req = "R8";
    mlo = 32'h0000_0765; mhi = '0;
    pin = 16'h0007; step(1); pin = '0; step(2);
    // R9 placement and ignored top nibble bit
    cur_req = "R9";
    mlo = 32'h0000_0000; mhi = 32'h0000_3A09;
    pin = 16'h0F00; step(1); pin = 16'h0000; step(1);
    pin = 16'h0E00; step(1); pulse_ack(16'h0FFF); step(1);
    mhi = '0; pin = '0; step(1); pulse_ack(16'h0FFF);
    // R10 lanes above NPINS
    cur_req = "R10";
    mlo = all_code(4'h4); mhi = all_code(4'h3);
    pin = 16'hF000; step(2); pin = 16'h0000; step(1);
    mhi = all_code(4'h2); step(2);
    pulse_ack(16'hFFFF); step(1);
    mhi = '0; mlo = '0; step(1); pulse_ack(16'hFFFF);
    // R11 masking and display
    cur_req = "R11";
    mlo = all_code(4'h1); pin = 16'h0030; step(1);
    mask = 16'h0010; step(1);
    mask = 16'h0030; step(1);
    en = 16'h0FCF; mask = '0; step(1);
    en = 16'hFFFF; step(1);
    pulse_ack(16'hFFFF); step(1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule